// File: doc/BRIEF.md
# Serial Control Frame Receiver

This block takes a 36-bit audio control word from a three-wire serial link: a data line, a serial clock, and an enable strobe that frames each word. The three lines are synchronised into the system clock domain and edge-detected, so the serial clock is never used as a clock. While the strobe is high, each rising serial-clock edge shifts one data bit in. When the strobe falls, a word of exactly 36 bits is copied into a staging register, and `frame_stb` pulses for one cycle. A word of any other length is dropped, and `frame_err` pulses instead.

The staging register is split into the settings of a two-channel audio path: the input source, the loudness switch, coarse and fine attenuation for each channel, three tone bands, and a fader level with front or rear routing. Attenuation, tone and fader codes are also converted to signed dB values, so a consumer does not need the nonlinear tables. `frame_stb` acts as a valid signal without a ready. The decoded outputs hold until the next accepted word, so no back-pressure is needed. A consumer may read them at any time after the pulse.

Top module: `ctl_frame_rx`

## Requirements
- R1: A word is shifted in first bit first, one bit for each rising `ser_clk` edge while `ser_en` is high. It is accepted on the falling edge of `ser_en`. Acceptance gives exactly one cycle of `frame_stb` and updates every decoded output in that same cycle.
- R2: Bit positions are counted from the first bit, and inside each field the earliest bit is the MSB. In order, the fields are: 2 ignored bits, 2-bit source code, loudness bit, channel 1 coarse (4 bits) and fine (3 bits), channel 2 coarse (4) and fine (3), then bass, mid and treble, each a 3-bit magnitude followed by a sign bit, then a 4-bit fader code and a fader route bit.
- R3: `src_pick` is one-hot. Source code 00 gives 0001, 01 gives 0010, 10 gives 0100, and 11 gives 1000.
- R4: Channel attenuation in dB, with coarse code c and fine code f: if c >= 5, the value is -(8*(15-c) + (7-f)). If c < 5, the channel is muted and reports -128.
- R5: Tone dB, with magnitude m: m=7 gives 15, otherwise 2*m. A sign bit of 1 means boost (positive) and 0 means cut (negative).
- R6: Fader dB, with code l: codes 0 to 10 give -2*l. Codes 11 to 14 give -25, -35, -45 and -60. Code 15 is mute and reports -128. Route bit 1 drives `fade_front` high (front), and 0 means rear.
- R7: If a word does not hold exactly 36 bits when the strobe falls, it is discarded. `frame_err` pulses for one cycle, no `frame_stb` is given, and all outputs keep their values.
- R8: Serial-clock edges while `ser_en` is low are ignored and do not disturb the next word.
- R9: After reset, the outputs are those of an all-zero word: source 1 (`src_pick`=0001), loudness off, both channels muted with fine code 0, all tones 0 dB, fader 0 dB routed to the rear.
- R10: Decoded outputs change only in a cycle with `frame_stb`.
- R11: The two leading bits have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| ser_dat | input | 1 | Serial data |
| ser_clk | input | 1 | Serial clock, sampled on its rising edge |
| ser_en | input | 1 | Word strobe; high frames a word |
| src_pick | output | 4 | One-hot input source |
| loud_on | output | 1 | Loudness enable |
| vol1_crs | output | 4 | Channel 1 coarse code |
| vol1_fin | output | 3 | Channel 1 fine code |
| vol2_crs | output | 4 | Channel 2 coarse code |
| vol2_fin | output | 3 | Channel 2 fine code |
| att1_db | output | 8 | Channel 1 attenuation, signed dB, -128 = mute |
| att2_db | output | 8 | Channel 2 attenuation, signed dB, -128 = mute |
| bass_db | output | 5 | Bass gain, signed dB |
| mid_db | output | 5 | Mid gain, signed dB |
| treb_db | output | 5 | Treble gain, signed dB |
| fade_db | output | 8 | Fader level, signed dB, -128 = mute |
| fade_front | output | 1 | Fader routes to front (1) or rear (0) |
| frame_stb | output | 1 | One-cycle pulse on an accepted word |
| frame_err | output | 1 | One-cycle pulse on a discarded word |

## Verification
The following properties are checked on every cycle:
- `frame_stb` lasts one cycle and never coincides with `frame_err`.
- The decoded outputs stay still between pulses.
- `src_pick` is one-hot.
- Low coarse codes always report mute.
- Tone values stay within their range.

Other behaviours need the bench's word sequences to show them:
- The bit order and field positions.
- The exact dB tables.
- The dropping of short and long words.
- The indifference to serial-clock edges while the strobe is low, and to the two leading bits.

// File: rtl/cfr_pkg.sv
`timescale 1ns/1ps
package cfr_pkg;
  localparam int FRAME_W = 36;

  typedef struct packed {
    logic [1:0] ign;
    logic [1:0] isel;
    logic       loud;
    logic [3:0] crs1;
    logic [2:0] fin1;
    logic [3:0] crs2;
    logic [2:0] fin2;
    logic [2:0] bmag;
    logic       bsgn;
    logic [2:0] mmag;
    logic       msgn;
    logic [2:0] tmag;
    logic       tsgn;
    logic [3:0] flvl;
    logic       fsel;
  } frame_t;

  localparam logic signed [7:0] DB_MUTE = -8'sd128;
  localparam logic [3:0] CRS_MIN_LIVE = 4'd5;

  function automatic logic signed [7:0] att_db(input logic [3:0] c, input logic [2:0] f);
    logic [7:0] steps;
    if (c < CRS_MIN_LIVE) return DB_MUTE;
    steps = {1'b0, ~c, 3'b000} + {5'b0, ~f};
    return -$signed(steps);
  endfunction

  function automatic logic signed [4:0] tone_db(input logic [2:0] m, input logic s);
    logic signed [4:0] mag;
    mag = (m == 3'd7) ? 5'sd15 : $signed({1'b0, m, 1'b0});
    return s ? mag : -mag;
  endfunction

  function automatic logic signed [7:0] fade_db(input logic [3:0] l);
    case (l)
      4'd11:   return -8'sd25;
      4'd12:   return -8'sd35;
      4'd13:   return -8'sd45;
      4'd14:   return -8'sd60;
      4'd15:   return DB_MUTE;
      default: return -$signed({3'b0, l, 1'b0});
    endcase
  endfunction
endpackage

// File: rtl/cfr_sync.sv
`timescale 1ns/1ps
module cfr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] st [STAGES];
  logic [W-1:0] prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_st
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= '0;
        else if (i == 0) st[i] <= din;
        else st[i] <= st[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else prev <= st[STAGES-1];
  end

  assign lvl  = st[STAGES-1];
  assign rise = st[STAGES-1] & ~prev;
  assign fall = ~st[STAGES-1] & prev;
endmodule

// File: rtl/cfr_shift.sv
`timescale 1ns/1ps
module cfr_shift #(
  parameter int FRAME_W = 36,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_lvl,
  input  logic               en_rise,
  input  logic               en_fall,
  input  logic               sck_rise,
  input  logic               dat,
  output logic [FRAME_W-1:0] stage,
  output logic               stb,
  output logic               err
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      cnt   <= '0;
      stage <= '0;
      stb   <= 1'b0;
      err   <= 1'b0;
    end else begin
      stb <= 1'b0;
      err <= 1'b0;
      if (en_fall) begin
        if (cnt == CNT_FULL) begin
          stage <= sh;
          stb   <= 1'b1;
        end else begin
          err <= 1'b1;
        end
        cnt <= '0;
      end else if (en_rise) begin
        cnt <= '0;
      end else if (en_lvl && sck_rise) begin
        sh <= {sh[FRAME_W-2:0], dat};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfr_decode.sv
`timescale 1ns/1ps
module cfr_decode
  import cfr_pkg::*;
(
  input  frame_t            f,
  output logic [3:0]        src_pick,
  output logic              loud_on,
  output logic [3:0]        vol1_crs,
  output logic [2:0]        vol1_fin,
  output logic [3:0]        vol2_crs,
  output logic [2:0]        vol2_fin,
  output logic signed [7:0] att1_db,
  output logic signed [7:0] att2_db,
  output logic signed [4:0] bass_db,
  output logic signed [4:0] mid_db,
  output logic signed [4:0] treb_db,
  output logic signed [7:0] fade_db,
  output logic              fade_front
);
  always_comb begin
    src_pick = 4'b0001 << f.isel;
    loud_on  = f.loud;
    vol1_crs = f.crs1;
    vol1_fin = f.fin1;
    vol2_crs = f.crs2;
    vol2_fin = f.fin2;
    att1_db  = att_db(f.crs1, f.fin1);
    att2_db  = att_db(f.crs2, f.fin2);
    bass_db  = tone_db(f.bmag, f.bsgn);
    mid_db   = tone_db(f.mmag, f.msgn);
    treb_db  = tone_db(f.tmag, f.tsgn);
    fade_db  = cfr_pkg::fade_db(f.flvl);
    fade_front = f.fsel;
  end
endmodule

// File: rtl/ctl_frame_rx.sv
`timescale 1ns/1ps
module ctl_frame_rx
  import cfr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_dat,
  input  logic        ser_clk,
  input  logic        ser_en,
  output logic [3:0]  src_pick,
  output logic        loud_on,
  output logic [3:0]  vol1_crs,
  output logic [2:0]  vol1_fin,
  output logic [3:0]  vol2_crs,
  output logic [2:0]  vol2_fin,
  output logic [7:0]  att1_db,
  output logic [7:0]  att2_db,
  output logic [4:0]  bass_db,
  output logic [4:0]  mid_db,
  output logic [4:0]  treb_db,
  output logic [7:0]  fade_db,
  output logic        fade_front,
  output logic        frame_stb,
  output logic        frame_err
);
  localparam int DAT = 0, SCK = 1, EN = 2;

  logic [2:0] s_lvl, s_rise, s_fall;
  logic [FRAME_W-1:0] stage;

  cfr_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({ser_en, ser_clk, ser_dat}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  cfr_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en_lvl(s_lvl[EN]), .en_rise(s_rise[EN]), .en_fall(s_fall[EN]),
    .sck_rise(s_rise[SCK]), .dat(s_lvl[DAT]),
    .stage(stage), .stb(frame_stb), .err(frame_err)
  );

  cfr_decode u_dec (
    .f(frame_t'(stage)),
    .src_pick(src_pick), .loud_on(loud_on),
    .vol1_crs(vol1_crs), .vol1_fin(vol1_fin),
    .vol2_crs(vol2_crs), .vol2_fin(vol2_fin),
    .att1_db(att1_db), .att2_db(att2_db),
    .bass_db(bass_db), .mid_db(mid_db), .treb_db(treb_db),
    .fade_db(fade_db), .fade_front(fade_front)
  );
endmodule

// File: rtl/ctl_frame_rx_chk.sv
`timescale 1ns/1ps
module ctl_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] src_pick,
  input logic       loud_on,
  input logic [3:0] vol1_crs,
  input logic [2:0] vol1_fin,
  input logic [3:0] vol2_crs,
  input logic [2:0] vol2_fin,
  input logic [7:0] att1_db,
  input logic [7:0] att2_db,
  input logic [4:0] bass_db,
  input logic [4:0] mid_db,
  input logic [4:0] treb_db,
  input logic [7:0] fade_db,
  input logic       fade_front,
  input logic       frame_stb,
  input logic       frame_err
);
  p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);

  p_no_err_with_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> !frame_err);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |-> $stable({src_pick, loud_on, vol1_crs, vol1_fin, vol2_crs, vol2_fin,
                            att1_db, att2_db, bass_db, mid_db, treb_db, fade_db, fade_front}));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_pick) == 1);

  p_mute1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vol1_crs < 4'd5) |-> (att1_db == 8'h80));

  p_mute2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vol2_crs < 4'd5) |-> (att2_db == 8'h80));

  p_bass_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(bass_db) <= 5'sd15) && ($signed(bass_db) >= -5'sd15));
endmodule

bind ctl_frame_rx ctl_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_pick(src_pick), .loud_on(loud_on),
  .vol1_crs(vol1_crs), .vol1_fin(vol1_fin), .vol2_crs(vol2_crs), .vol2_fin(vol2_fin),
  .att1_db(att1_db), .att2_db(att2_db), .bass_db(bass_db), .mid_db(mid_db),
  .treb_db(treb_db), .fade_db(fade_db), .fade_front(fade_front),
  .frame_stb(frame_stb), .frame_err(frame_err)
);

// File: tb/sim_ctl_frame_rx.sv
`timescale 1ns/1ps
module sim_ctl_frame_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_dat = 1'b0, ser_clk = 1'b0, ser_en = 1'b0;
  logic [3:0] src_pick; logic loud_on;
  logic [3:0] vol1_crs, vol2_crs; logic [2:0] vol1_fin, vol2_fin;
  logic [7:0] att1_db, att2_db, fade_db;
  logic [4:0] bass_db, mid_db, treb_db;
  logic fade_front, frame_stb, frame_err;

  int errs = 0, checks = 0;
  int got_stb, got_err;
  logic [35:0] last_ok;

  always #10 clk = ~clk;

  ctl_frame_rx u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int e_att(input int c, input int f);
    if (c < 5) return -128;
    return -(8*(15-c) + (7-f));
  endfunction
  function automatic int e_tone(input int m, input int s);
    int v;
    v = (m == 7) ? 15 : 2*m;
    return s ? v : -v;
  endfunction
  function automatic int e_fade(input int l);
    case (l)
      11: return -25; 12: return -35; 13: return -45; 14: return -60; 15: return -128;
      default: return -2*l;
    endcase
  endfunction

  // bit n-1 of 'bits' goes out first
  task automatic send(input logic [63:0] bits, input int n);
    got_stb = 0; got_err = 0;
    ser_en = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = n-1; i >= 0; i--) begin
      ser_dat = bits[i];
      repeat (5) @(negedge clk);
      ser_clk = 1'b1;
      repeat (5) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (5) @(negedge clk);
    ser_en = 1'b0;
    repeat (12) @(negedge clk) begin
      if (frame_stb) got_stb++;
      if (frame_err) got_err++;
    end
    repeat (4) @(negedge clk);
  endtask

  // field positions per R2: word bit 35 is the first bit
  task automatic check_word(input logic [35:0] w, input string tag);
    chk(src_pick == (4'b0001 << w[33:32]), {tag, " R3 src"}, src_pick, 1 << w[33:32]);
    chk(loud_on == w[31], {tag, " R2 loud"}, loud_on, w[31]);
    chk(vol1_crs == w[30:27] && vol1_fin == w[26:24], {tag, " R2 ch1 codes"},
        {vol1_crs, vol1_fin}, w[30:24]);
    chk(vol2_crs == w[23:20] && vol2_fin == w[19:17], {tag, " R2 ch2 codes"},
        {vol2_crs, vol2_fin}, w[23:17]);
    chk($signed(att1_db) == e_att(w[30:27], w[26:24]), {tag, " R4 att1"},
        $signed(att1_db), e_att(w[30:27], w[26:24]));
    chk($signed(att2_db) == e_att(w[23:20], w[19:17]), {tag, " R4 att2"},
        $signed(att2_db), e_att(w[23:20], w[19:17]));
    chk($signed(bass_db) == e_tone(w[16:14], w[13]), {tag, " R5 bass"},
        $signed(bass_db), e_tone(w[16:14], w[13]));
    chk($signed(mid_db) == e_tone(w[12:10], w[9]), {tag, " R5 mid"},
        $signed(mid_db), e_tone(w[12:10], w[9]));
    chk($signed(treb_db) == e_tone(w[8:6], w[5]), {tag, " R5 treble"},
        $signed(treb_db), e_tone(w[8:6], w[5]));
    chk($signed(fade_db) == e_fade(w[4:1]), {tag, " R6 fader"},
        $signed(fade_db), e_fade(w[4:1]));
    chk(fade_front == w[0], {tag, " R6 route"}, fade_front, w[0]);
  endtask

  task automatic good(input logic [35:0] w, input string tag);
    send({28'b0, w}, 36);
    chk(got_stb == 1 && got_err == 0, {tag, " R1 one stb"}, got_stb, 1);
    last_ok = w;
    check_word(w, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    last_ok = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R9 reset state equals all-zero word
    chk(frame_stb == 0 && frame_err == 0, "R9 no pulse", frame_stb, 0);
    check_word(36'd0, "R9 reset");

    good('1, "R1 all ones");
    good({2'b00, 2'b10, 1'b0, 4'd5, 3'd3, 4'd4, 3'd7, 3'd3, 1'b0, 3'd7, 1'b1, 3'd0, 1'b0, 4'd11, 1'b1},
         "R4 boundary");
    for (int l = 10; l <= 15; l++)
      good({2'b01, 2'b01, 1'b1, 4'd15, 3'd0, 4'd6, 3'd7, 3'd6, 1'b1, 3'd1, 1'b0, 3'd2, 1'b1, 4'(l), 1'b0},
           "R6 fader steps");

    // R11: leading bits changed, everything else same
    begin
      logic [35:0] w;
      w = {2'b00, 34'h2_3456_789A};
      good(w, "R11 base");
      w[35:34] = 2'b11;
      good(w, "R11 lead bits");
    end

    // R7: short and long words dropped
    send(64'h0_FFFF_FFFF, 35);
    chk(got_err == 1 && got_stb == 0, "R7 short word err", got_err, 1);
    check_word(last_ok, "R7 short hold");
    send(64'h1F_FFFF_FFFF, 37);
    chk(got_err == 1 && got_stb == 0, "R7 long word err", got_err, 1);
    check_word(last_ok, "R7 long hold");

    // R8: serial clock edges while strobe low
    got_stb = 0;
    for (int k = 0; k < 6; k++) begin
      ser_dat = k[0];
      repeat (5) @(negedge clk); ser_clk = 1'b1;
      repeat (5) @(negedge clk) if (frame_stb || frame_err) got_stb++;
      ser_clk = 1'b0;
    end
    chk(got_stb == 0, "R8 no pulse while strobe low", got_stb, 0);
    check_word(last_ok, "R8 held");
    good(36'h9_8765_4321, "R8 next word");

    // random words, R10 hold checked after idle gap
    for (int r = 0; r < 30; r++) begin
      logic [35:0] w;
      w = {$urandom(), $urandom()};
      good(w, "R2 random");
      repeat (20) @(negedge clk);
      chk(src_pick == (4'b0001 << w[33:32]) && $signed(fade_db) == e_fade(w[4:1]),
          "R10 hold", $signed(fade_db), e_fade(w[4:1]));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule